// File: doc/BRIEF.md
# Sprite Attribute Table Host Write Port

This block sits between a byte-wide host bus and a 544-byte sprite attribute store. The store has two regions: a 512-byte main table, whose bytes are committed two at a time, and a 32-byte high table, whose bytes are written one at a time. The host first sets a 9-bit base pointer through two byte registers. It then streams bytes through a data register. Each streamed byte advances a 10-bit internal byte pointer.

In the main table, the block holds each even-addressed byte in a one-byte latch. When the following odd byte arrives, it writes both bytes together. When the pointer's top bit is set, the access goes to the high table directly, and only the low five pointer bits select the byte. A priority-rotation flag, carried in the upper base register, makes the block publish a first-sprite index taken from the pointer. While the picture is being drawn, the block redirects every write and read to a single fixed byte. The picture counts as being drawn when the display is enabled and the current line is below the active height.

Top module: `spriteTablePort`

## Requirements
- R1: After reset, byteAddr, priorityOn, firstSprite and readData are all 0.
- R2: A write with hostSel = 0 loads hostData into base bits 7:0, and byteAddr becomes the 9-bit base shifted left by one (bit 0 = 0).
- R3: A write with hostSel = 1 loads hostData bit 0 into base bit 8 and hostData bit 7 into priorityOn, and byteAddr reloads as in R2.
- R4: A data write (hostSel = 2) at a main-table address (byteAddr bit 9 = 0) with byteAddr bit 0 = 0 only captures the byte into the latch, and no table byte changes.
- R5: A data write at a main-table odd address stores the latched byte at address byteAddr-1 and the new byte at byteAddr.
- R6: A data write with byteAddr bit 9 = 1 stores the byte directly at table index 0x200 + byteAddr[4:0], with no latch involvement.
- R7: Every data write increments byteAddr by one, and 0x3FF wraps to 0x000.
- R8: firstSprite is 0 while priorityOn = 0. While priorityOn = 1, firstSprite equals byteAddr[8:2] after every base or data write.
- R9: While displayOn = 1 and lineNum < activeHeight, data writes that would store a byte store it at table index 0x218 instead. Even main-table writes still only latch. Reads return index 0x218. byteAddr still advances.
- R10: A read with hostSel = 2 (and hostWr = 0) makes readData show the byte at the mapped byteAddr one cycle later, without changing byteAddr. Reads with any other hostSel leave readData unchanged, and writes with hostSel = 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Write strobe, one byte per cycle |
| hostRd | input | 1 | Read strobe |
| hostSel | input | 2 | 0 base low, 1 base high and priority, 2 data, 3 unused |
| hostData | input | 8 | Write byte |
| displayOn | input | 1 | Display enabled |
| lineNum | input | 9 | Current line number |
| activeHeight | input | 9 | Number of visible lines |
| byteAddr | output | 10 | Internal byte pointer |
| priorityOn | output | 1 | Priority rotation flag |
| firstSprite | output | 7 | Index of the first sprite to evaluate |
| readData | output | 8 | Byte returned by the last data read |

## Verification
A wrong pointer or base value shows on byteAddr and firstSprite in the cycle after the offending write. A latch that holds a stale byte, or a misrouted write lane, stays hidden until a later data read returns a wrong byte. The bench therefore re-points the base and reads back each even and odd byte after each pairing case. A gating decision that goes wrong either corrupts a byte outside index 0x218 or leaves 0x218 unchanged, and the bench catches both on the next read-back with the display gate closed.

// File: rtl/spriteTablePkg.sv
package spriteTablePkg;

  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_NONE    = 2'd3
  } hostSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic dataWr;
    logic dataRd;
    logic gated;
  } tableStrobe_t;

endpackage

// File: rtl/spriteTableCtrl.sv
module spriteTableCtrl
  import spriteTablePkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostSel,
  input  logic              displayOn,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [LINE_W-1:0] activeHeight,
  output tableStrobe_t      stb
);

  hostSel_t selCode;
  logic     drawing;

  assign selCode = hostSel_t'(hostSel);

  // picture is being drawn: table is locked to the fixed byte
  assign drawing = displayOn && (lineNum < activeHeight);

  always_comb begin
    stb        = '0;
    stb.gated  = drawing;
    if (hostWr) begin
      unique case (selCode)
        SEL_BASE_LO: stb.loadLo = 1'b1;
        SEL_BASE_HI: stb.loadHi = 1'b1;
        SEL_DATA:    stb.dataWr = 1'b1;
        default:     ;
      endcase
    end else if (hostRd && selCode == SEL_DATA) begin
      stb.dataRd = 1'b1;
    end
  end

endmodule

// File: rtl/spriteTableDatapath.sv
module spriteTableDatapath
  import spriteTablePkg::*;
#(
  parameter int BASE_W    = 9,
  parameter int HI_BITS   = 5,
  parameter int GATE_BYTE = 536
) (
  input  logic              clk,
  input  logic              rstN,
  input  tableStrobe_t      stb,
  input  logic [7:0]        wrByte,
  output logic [BASE_W:0]   byteAddr,
  output logic              priorityOn,
  output logic [BASE_W-3:0] firstSprite,
  output logic [7:0]        readData
);

  localparam int ADDR_W     = BASE_W + 1;
  localparam int FIRST_W    = BASE_W - 2;
  localparam int MAIN_BYTES = 1 << BASE_W;
  localparam int HI_BYTES   = 1 << HI_BITS;
  localparam int DEPTH      = MAIN_BYTES + HI_BYTES;
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int LANES      = 2;
  localparam logic [IDX_W-1:0] GATE_IDX = IDX_W'(GATE_BYTE);

  logic [BASE_W-1:0] baseAddr;
  logic [7:0]        pairLatch;
  logic [7:0]        tableMem [DEPTH];

  logic [BASE_W-1:0]  nextBase;
  logic               nextPrio;
  logic [ADDR_W-1:0]  nextAddr;
  logic [FIRST_W-1:0] nextFirst;
  logic               ptrUpdate;

  logic              inHigh;
  logic              oddByte;
  logic              latchCapture;
  logic [IDX_W-1:0]  mappedIdx;
  logic [IDX_W-1:0]  evenIdx;
  logic [IDX_W-1:0]  readIdx;

  logic             laneEn   [LANES];
  logic [IDX_W-1:0] laneIdx  [LANES];
  logic [7:0]       laneData [LANES];

  function automatic logic [IDX_W-1:0] toIndex(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1])
      return IDX_W'(MAIN_BYTES) + IDX_W'(a[HI_BITS-1:0]);
    else
      return IDX_W'(a[ADDR_W-2:0]);
  endfunction

  // pointer / base next state
  always_comb begin
    nextBase = baseAddr;
    nextPrio = priorityOn;
    nextAddr = byteAddr;
    if (stb.loadLo) begin
      nextBase[7:0] = wrByte;
      nextAddr      = {nextBase, 1'b0};
    end else if (stb.loadHi) begin
      nextBase[BASE_W-1] = wrByte[0];
      nextPrio           = wrByte[7];
      nextAddr           = {nextBase, 1'b0};
    end else if (stb.dataWr) begin
      nextAddr = byteAddr + ADDR_W'(1);
    end
    nextFirst = nextPrio ? nextAddr[BASE_W-1:2] : '0;
  end

  assign ptrUpdate = stb.loadLo | stb.loadHi | stb.dataWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr    <= '0;
      priorityOn  <= 1'b0;
      byteAddr    <= '0;
      firstSprite <= '0;
    end else if (ptrUpdate) begin
      baseAddr    <= nextBase;
      priorityOn  <= nextPrio;
      byteAddr    <= nextAddr;
      firstSprite <= nextFirst;
    end
  end

  // write routing
  assign inHigh       = byteAddr[ADDR_W-1];
  assign oddByte      = byteAddr[0];
  assign mappedIdx    = toIndex(byteAddr);
  assign evenIdx      = IDX_W'({byteAddr[ADDR_W-2:1], 1'b0});
  assign latchCapture = stb.dataWr && !inHigh && !oddByte;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneEn[l]   = 1'b0;
      laneIdx[l]  = '0;
      laneData[l] = '0;
    end
    if (stb.dataWr && (inHigh || oddByte)) begin
      if (stb.gated) begin
        // only the final byte of the access survives at the fixed slot
        laneEn[1]   = 1'b1;
        laneIdx[1]  = GATE_IDX;
        laneData[1] = wrByte;
      end else if (inHigh) begin
        laneEn[1]   = 1'b1;
        laneIdx[1]  = mappedIdx;
        laneData[1] = wrByte;
      end else begin
        laneEn[0]   = 1'b1;
        laneIdx[0]  = evenIdx;
        laneData[0] = pairLatch;
        laneEn[1]   = 1'b1;
        laneIdx[1]  = mappedIdx;
        laneData[1] = wrByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pairLatch <= '0;
    else if (latchCapture)
      pairLatch <= wrByte;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (laneEn[l]) tableMem[laneIdx[l]] <= laneData[l];
    end
  end

  // read path
  assign readIdx = stb.gated ? GATE_IDX : mappedIdx;

  always_ff @(posedge clk) begin
    if (!rstN)
      readData <= '0;
    else if (stb.dataRd)
      readData <= tableMem[readIdx];
  end

endmodule

// File: rtl/spriteTablePort.sv
module spriteTablePort
  import spriteTablePkg::*;
#(
  parameter int BASE_W    = 9,
  parameter int HI_BITS   = 5,
  parameter int LINE_W    = 9,
  parameter int GATE_BYTE = 536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostData,
  input  logic              displayOn,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [LINE_W-1:0] activeHeight,
  output logic [BASE_W:0]   byteAddr,
  output logic              priorityOn,
  output logic [BASE_W-3:0] firstSprite,
  output logic [7:0]        readData
);

  localparam int ADDR_W  = BASE_W + 1;
  localparam int FIRST_W = BASE_W - 2;

  tableStrobe_t stb;

  spriteTableCtrl #(
    .LINE_W(LINE_W)
  ) uCtrl (
    .hostWr      (hostWr),
    .hostRd      (hostRd),
    .hostSel     (hostSel),
    .displayOn   (displayOn),
    .lineNum     (lineNum),
    .activeHeight(activeHeight),
    .stb         (stb)
  );

  spriteTableDatapath #(
    .BASE_W   (BASE_W),
    .HI_BITS  (HI_BITS),
    .GATE_BYTE(GATE_BYTE)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrByte     (hostData),
    .byteAddr   (byteAddr),
    .priorityOn (priorityOn),
    .firstSprite(firstSprite),
    .readData   (readData)
  );

endmodule

// File: rtl/spriteTableChecker.sv
module spriteTableChecker #(
  parameter int ADDR_W  = 10,
  parameter int FIRST_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWr,
  input logic               hostRd,
  input logic [1:0]         hostSel,
  input logic [7:0]         hostData,
  input logic [ADDR_W-1:0]  byteAddr,
  input logic               priorityOn,
  input logic [FIRST_W-1:0] firstSprite,
  input logic [7:0]         readData
);

  assert_base_lo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd0) |=>
      (byteAddr[ADDR_W-2:1] == $past(hostData) && byteAddr[0] == 1'b0));

  assert_base_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd1) |=>
      (byteAddr[ADDR_W-1] == $past(hostData[0]) && priorityOn == $past(hostData[7])
       && byteAddr[0] == 1'b0));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd2) |=> (byteAddr == $past(byteAddr) + ADDR_W'(1)));

  assert_first_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !priorityOn |-> (firstSprite == '0));

  assert_first_track_R8: assert property (@(posedge clk) disable iff (!rstN)
    priorityOn |-> (firstSprite == byteAddr[ADDR_W-2:2]));

  assert_idle_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWr || hostSel == 2'd3) |=> ($stable(byteAddr) && $stable(priorityOn)));

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd && !hostWr && hostSel == 2'd2) |=> $stable(readData));

endmodule

bind spriteTablePort spriteTableChecker #(
  .ADDR_W (ADDR_W),
  .FIRST_W(FIRST_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWr     (hostWr),
  .hostRd     (hostRd),
  .hostSel    (hostSel),
  .hostData   (hostData),
  .byteAddr   (byteAddr),
  .priorityOn (priorityOn),
  .firstSprite(firstSprite),
  .readData   (readData)
);

// File: tb/sim_spriteTablePort.sv
module sim_spriteTablePort;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 544;
  localparam int GATE_IDX   = 536;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostWr, hostRd;
  logic [1:0] hostSel;
  logic [7:0] hostData;
  logic       displayOn;
  logic [8:0] lineNum, activeHeight;
  logic [9:0] byteAddr;
  logic       priorityOn;
  logic [6:0] firstSprite;
  logic [7:0] readData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [7:0] refMem [DEPTH];
  logic [8:0] refBase;
  logic [9:0] refAddr;
  logic       refPrio;
  logic [7:0] refLatch;
  logic [7:0] lastRead;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen;

  spriteTablePort u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostData(hostData), .displayOn(displayOn), .lineNum(lineNum),
    .activeHeight(activeHeight), .byteAddr(byteAddr), .priorityOn(priorityOn),
    .firstSprite(firstSprite), .readData(readData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mapIdx(logic [9:0] a);
    if (displayOn && lineNum < activeHeight) return GATE_IDX;
    if (a[9]) return 512 + int'(a[4:0]);
    return int'(a[8:0]);
  endfunction

  // monitor: compares each read result with the queued expectation
  always @(posedge clk) rdSeen <= hostRd && !hostWr && hostSel == 2'd2;

  always @(negedge clk) begin
    if (rdSeen && rstN) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected read", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, readData, e);
        lastRead = e;
      end
    end
  end

  task automatic wrReg(logic [1:0] sel, logic [7:0] d, string tag);
    bit gated;
    gated    = displayOn && lineNum < activeHeight;
    hostWr   = 1'b1;
    hostSel  = sel;
    hostData = d;
    @(negedge clk);
    hostWr = 1'b0;
    case (sel)
      2'd0: begin refBase[7:0] = d; refAddr = {refBase, 1'b0}; end
      2'd1: begin refBase[8] = d[0]; refPrio = d[7]; refAddr = {refBase, 1'b0}; end
      2'd2: begin
        if (!refAddr[9] && !refAddr[0]) refLatch = d;
        else if (gated) refMem[GATE_IDX] = d;
        else if (refAddr[9]) refMem[512 + int'(refAddr[4:0])] = d;
        else begin
          refMem[int'({refAddr[8:1], 1'b0})] = refLatch;
          refMem[int'(refAddr[8:0])] = d;
        end
        refAddr = refAddr + 10'd1;
      end
      default: ;
    endcase
    check({tag, " byteAddr"}, byteAddr, refAddr);
    check({tag, " priorityOn"}, priorityOn, refPrio);
    check({tag, " firstSprite"}, firstSprite, refPrio ? int'(refAddr[8:2]) : 0);
  endtask

  task automatic setBase(logic [8:0] b, bit prio, string tag);
    wrReg(2'd1, {prio, 6'd0, b[8]}, tag);
    wrReg(2'd0, b[7:0], tag);
  endtask

  task automatic rdData(string tag);
    expQ.push_back(refMem[mapIdx(refAddr)]);
    tagQ.push_back(tag);
    hostRd  = 1'b1;
    hostSel = 2'd2;
    @(negedge clk);
    hostRd = 1'b0;
    @(negedge clk);
    check({tag, " addr kept"}, byteAddr, refAddr);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    refBase = '0; refAddr = '0; refPrio = 0; refLatch = '0; lastRead = '0;
    rstN = 0; hostWr = 0; hostRd = 0; hostSel = 0; hostData = 0;
    displayOn = 0; lineNum = 9'd300; activeHeight = 9'd225;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 byteAddr", byteAddr, 0);
    check("R1 priorityOn", priorityOn, 0);
    check("R1 firstSprite", firstSprite, 0);
    check("R1 readData", readData, 0);

    // base registers and priority rotation
    wrReg(2'd0, 8'h05, "R2 base low");
    wrReg(2'd1, 8'h80, "R3 base high prio");
    check("R8 first after base", firstSprite, 2);

    // pairing through latch
    wrReg(2'd2, 8'hAA, "R4 even");
    wrReg(2'd2, 8'hBB, "R5 odd");
    setBase(9'h005, 1'b1, "R2 reload");
    rdData("R5 even byte");
    wrReg(2'd2, 8'hCC, "R4 latch only");
    rdData("R4 odd byte untouched");
    setBase(9'h005, 1'b1, "R2 reload2");
    rdData("R4 even byte untouched");

    // high table direct writes and aliasing
    setBase(9'h105, 1'b0, "R3 high table");
    wrReg(2'd2, 8'h5A, "R6 direct even");
    wrReg(2'd2, 8'h6B, "R6 direct odd");
    setBase(9'h105, 1'b0, "R6 reload");
    rdData("R6 even high byte");
    setBase(9'h11F, 1'b0, "R6 alias base");
    wrReg(2'd2, 8'h77, "R6 alias write");
    setBase(9'h10F, 1'b0, "R6 alias read base");
    rdData("R6 aliased byte");

    // wrap
    setBase(9'h1FF, 1'b1, "R7 top base");
    wrReg(2'd2, 8'h12, "R7 step");
    wrReg(2'd2, 8'h34, "R7 wrap");
    check("R7 wrapped to zero", byteAddr, 0);

    // priority tracking through data writes
    setBase(9'h007, 1'b1, "R8 prio base");
    wrReg(2'd2, 8'h41, "R8 data");
    wrReg(2'd2, 8'h42, "R8 data");
    wrReg(2'd2, 8'h43, "R8 data");
    setBase(9'h007, 1'b0, "R8 prio off");

    // display gating
    setBase(9'h020, 1'b0, "R9 prep");
    wrReg(2'd2, 8'h31, "R9 prep");
    wrReg(2'd2, 8'h32, "R9 prep");
    displayOn = 1; lineNum = 9'd10;
    setBase(9'h020, 1'b0, "R9 gated base");
    wrReg(2'd2, 8'hD1, "R9 gated even");
    wrReg(2'd2, 8'hD2, "R9 gated odd");
    rdData("R9 gated read");
    setBase(9'h130, 1'b0, "R9 gated high base");
    wrReg(2'd2, 8'hE7, "R9 gated high");
    lineNum = 9'd225;
    setBase(9'h020, 1'b0, "R9 open");
    rdData("R9 main byte kept");
    setBase(9'h10C, 1'b0, "R9 fixed slot");
    rdData("R9 fixed slot value");
    setBase(9'h130, 1'b0, "R9 high kept");
    rdData("R9 high byte not written");
    displayOn = 0; lineNum = 9'd10;
    setBase(9'h10C, 1'b0, "R9 display off");
    wrReg(2'd2, 8'h99, "R9 display off write");
    setBase(9'h10C, 1'b0, "R9 display off reload");
    rdData("R9 display off direct");

    // ignored accesses
    wrReg(2'd3, 8'hFF, "R10 sel3 write");
    hostRd = 1; hostSel = 2'd0;
    @(negedge clk);
    hostRd = 0;
    @(negedge clk);
    check("R10 read with other select", readData, lastRead);

    repeat (2) @(negedge clk);
    check("R10 queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule